// File: doc/BRIEF.md
# Latched 16-bit Interval Timer

A 16-bit down-counter with a 16-bit reload latch. It is reached through a byte-wide register port. Each cycle in which the clock-enable input `tick` is high moves the counter one step down. When a tick brings the counter to zero, the block raises a one-cycle interrupt-set pulse and a sticky pending flag. The host programs the reload value one byte at a time. Writing the high counter byte commits the whole latch into the counter and starts a new interval.

Bit 6 of the control byte selects the mode. In one-shot mode the counter keeps running after zero and wraps, but only the first zero after a load raises an interrupt. In continuous mode the counter goes down through zero to 0xFFFF. On the following tick it reloads from the latch, so the interval is the latch value plus two ticks.

Top module: `ival_timer`

## Requirements
- R1: After a synchronous active-low reset, the latch and the counter both hold 0xFFFF, and the control byte reads 0x00. `irq_set` and `irq_flag` are low.
- R2: A write to address 0 (counter low) or address 2 (latch low) replaces only latch bits 7:0. It leaves the counter and latch bits 15:8 unchanged.
- R3: A write to address 1 (counter high) stores latch bits 15:8. On the next edge it loads the full new latch into the counter and clears `irq_flag`. If a tick falls in the same cycle, the write wins.
- R4: A write to address 3 (latch high) stores latch bits 15:8 and clears `irq_flag`. It does not load the counter.
- R5: Each cycle with `tick` high and no load, the counter decrements by one, wrapping from 0x0000 to 0xFFFF. Without a tick or a load, the counter holds.
- R6: When a tick takes the counter to zero, `irq_set` is high for exactly the next cycle and `irq_flag` becomes 1. If a latch-high write falls in the same cycle, setting the flag wins over clearing it. A counter that reaches zero by a load raises nothing.
- R7: With control bit 6 clear (one-shot), only the first zero reached after a load or a reset raises `irq_set`. Later zeros raise nothing.
- R8: With control bit 6 set (continuous), a tick while the counter is 0xFFFF reloads the counter from the latch, giving `irq_set` pulses every latch+2 ticks. A control write changes the mode from the next tick on.
- R9: `rdata` is combinational from `addr`. Address 0 returns counter bits 7:0, 1 returns counter bits 15:8, 2 and 3 return latch bits 7:0 and 15:8, and 4 returns the control byte. Addresses 5 to 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_set | output | 1 | One-cycle pulse when a tick reaches zero |
| irq_flag | output | 1 | Sticky pending flag |

## Verification
The assertions check, on every cycle, the step rules of the counter. These are loading the latch on a counter-high write, holding without a tick, decrementing by one, and reloading from the latch at 0xFFFF in continuous mode. They also check that every `irq_set` pulse sees a zero counter and a set flag, and that a one-shot timer that has already fired stays quiet. Only the bench scenarios can show the properties that span many cycles or the register port. These are the latch+2 continuous period, the full 65536-tick wrap with no second one-shot interrupt, the byte-lane isolation of latch writes, and the flag priority against a clearing write in the same cycle.

// File: rtl/ival_timer_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and shared constants for the interval timer.
package ival_timer_pkg;
    localparam int ADDR_W = 3;

    // Register map; counter-high must stay distinct from latch-high since
    // only the former commits the latch into the counter.
    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_LO = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_LAT_LO = 3'd2,
        RA_LAT_HI = 3'd3,
        RA_CTRL   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/ival_timer_regs.sv
`timescale 1ns/1ps
// ival_timer_regs: holds the reload latch and control byte, decodes writes.
// Assumes byte-wide writes; latch is two DATA_W lanes. Produces the load
// request and value for the counter and the flag-clear strobe.
module ival_timer_regs
    import ival_timer_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MODE_BIT = 6,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  latch_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              cont_mode,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val,
    output logic              flag_clr
);
    logic wr_lo, wr_hi;

    // Decode write strobes for each lane.
    always_comb begin
        wr_lo    = wr_en && (addr == RA_CNT_LO || addr == RA_LAT_LO);
        wr_hi    = wr_en && (addr == RA_CNT_HI || addr == RA_LAT_HI);
        load_req = wr_en && (addr == RA_CNT_HI);
        flag_clr = wr_hi;
        load_val = {wdata, latch_q[DATA_W-1:0]};
        cont_mode = ctrl_q[MODE_BIT];
    end

    // Latch low lane.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q[DATA_W-1:0] <= '1;
        else if (wr_lo) latch_q[DATA_W-1:0] <= wdata;
    end

    // Latch high lane.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q[CNT_W-1:DATA_W] <= '1;
        else if (wr_hi) latch_q[CNT_W-1:DATA_W] <= wdata;
    end

    // Control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (wr_en && addr == RA_CTRL)     ctrl_q <= wdata;
    end
endmodule

// File: rtl/ival_timer_count.sv
`timescale 1ns/1ps
// ival_timer_count: the down-counter. A load wins over a tick. In
// continuous mode a tick at all-ones reloads from the latch. Flags the
// cycle in which a tick will bring the count to zero.
module ival_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cont,
    input  logic [CNT_W-1:0] latch,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero_hit
);
    logic [CNT_W-1:0] step_val;
    logic             at_top;

    // Next value for a tick: reload or decrement.
    always_comb begin
        at_top   = (cnt_q == '1);
        step_val = (cont && at_top) ? latch : cnt_q - 1'b1;
        zero_hit = tick && !load && (step_val == '0);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '1;
        else if (load)  cnt_q <= load_val;
        else if (tick)  cnt_q <= step_val;
    end

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
    // R5
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !(cont && cnt_q == '1)) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cont && cnt_q == '1) |=> cnt_q == $past(latch));
endmodule

// File: rtl/ival_timer_event.sv
`timescale 1ns/1ps
// ival_timer_event: turns zero hits into the interrupt pulse and pending
// flag. Tracks one-shot arming: a load (or reset) arms, any zero disarms.
module ival_timer_event (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_hit,
    input  logic load,
    input  logic cont,
    input  logic flag_clr,
    output logic irq_set,
    output logic flag_q
);
    logic armed_q;
    logic fire;

    // Decide whether this zero is reported.
    always_comb fire = zero_hit && (cont || armed_q);

    // Arm on load, disarm on any zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b1;
        else if (load)     armed_q <= 1'b1;
        else if (zero_hit) armed_q <= 1'b0;
    end

    // Pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_set <= 1'b0;
        else        irq_set <= fire;
    end

    // Pending flag; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // R6
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> flag_q);
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> !irq_set);
    // R7
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !cont && !load) |=> !irq_set);
endmodule

// File: rtl/ival_timer.sv
`timescale 1ns/1ps
// ival_timer: top of the latched interval timer. Wires the register
// file, counter and event logic, and muxes read data. Assumes a single
// clock domain and a synchronous active-low reset.
module ival_timer
    import ival_timer_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MODE_BIT = 6,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_set,
    output logic              irq_flag
);
    logic [CNT_W-1:0]  latch_q, load_val, cnt_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              cont_mode, load_req, flag_clr, zero_hit;

    ival_timer_regs #(.DATA_W(DATA_W), .MODE_BIT(MODE_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .latch_q(latch_q), .ctrl_q(ctrl_q), .cont_mode(cont_mode),
        .load_req(load_req), .load_val(load_val), .flag_clr(flag_clr)
    );

    ival_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_req),
        .load_val(load_val), .cont(cont_mode), .latch(latch_q),
        .cnt_q(cnt_q), .zero_hit(zero_hit)
    );

    ival_timer_event u_event (
        .clk(clk), .rst_n(rst_n), .zero_hit(zero_hit), .load(load_req),
        .cont(cont_mode), .flag_clr(flag_clr),
        .irq_set(irq_set), .flag_q(irq_flag)
    );

    // Read mux by address.
    always_comb begin
        case (addr)
            RA_CNT_LO: rdata = cnt_q[DATA_W-1:0];
            RA_CNT_HI: rdata = cnt_q[CNT_W-1:DATA_W];
            RA_LAT_LO: rdata = latch_q[DATA_W-1:0];
            RA_LAT_HI: rdata = latch_q[CNT_W-1:DATA_W];
            RA_CTRL:   rdata = ctrl_q;
            default:   rdata = '0;
        endcase
    end

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> cnt_q == '0);
endmodule

// File: tb/ival_timer_tb.sv
`timescale 1ns/1ps
module ival_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq_set, irq_flag;
    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] m_cnt, m_lat;
    logic [7:0]  m_ctrl;
    bit m_armed, m_flag, m_irq;

    always #2.5 clk = ~clk;

    ival_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_set(irq_set),
        .irq_flag(irq_flag));

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 16'hFFFF; m_lat = 16'hFFFF; m_ctrl = 8'h00;
        m_armed = 1; m_flag = 0; m_irq = 0;
    endtask

    // Advance the model by one edge, from pre-edge state and inputs.
    task automatic model_step(bit w, logic [2:0] a, logic [7:0] d, bit tk);
        bit cont = m_ctrl[6];
        bit load = w && a == 3'd1;
        bit hit = 0;
        logic [15:0] nxt;
        if (load) begin
            m_cnt = {d, m_lat[7:0]};
            m_armed = 1;
        end else if (tk) begin
            nxt = (cont && m_cnt == 16'hFFFF) ? m_lat : m_cnt - 16'd1;
            if (nxt == 16'd0) begin
                hit = cont || m_armed;
                m_armed = 0;
            end
            m_cnt = nxt;
        end
        if (hit) m_flag = 1;
        else if (w && (a == 3'd1 || a == 3'd3)) m_flag = 0;
        m_irq = hit;
        if (w) begin
            case (a)
                3'd0, 3'd2: m_lat[7:0] = d;
                3'd1, 3'd3: m_lat[15:8] = d;
                3'd4: m_ctrl = d;
                default: ;
            endcase
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_cnt[7:0];
            3'd1: return m_cnt[15:8];
            3'd2: return m_lat[7:0];
            3'd3: return m_lat[15:8];
            3'd4: return m_ctrl;
            default: return 8'h00;
        endcase
    endfunction

    // One clock with given stimulus; checks pulse and flag after the edge.
    task automatic cyc(bit w, logic [2:0] a, logic [7:0] d, bit tk);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick = tk;
        @(posedge clk);
        model_step(w, a, d, tk);
        #1;
        check("R6 irq_set", {15'd0, irq_set}, {15'd0, m_irq});
        check("R6 irq_flag", {15'd0, irq_flag}, {15'd0, m_flag});
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        wr_en = 0; tick = 0; addr = a;
        #1;
        check(tag, {8'd0, rdata}, {8'd0, exp_rd(a)});
        @(posedge clk);
        model_step(0, a, 8'h00, 0);
    endtask

    task automatic rd_all(string tag);
        for (int a = 0; a < 8; a++) rd(3'(a), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t_last, t_now, pulses;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state and R9 read map
        check("R1 irq_set", {15'd0, irq_set}, 16'd0);
        check("R1 irq_flag", {15'd0, irq_flag}, 16'd0);
        rd_all("R1/R9 reset readback");

        // R2 low-lane writes leave counter alone
        cyc(1, 3'd0, 8'h34, 0);
        rd_all("R2 after cnt-lo write");
        cyc(1, 3'd2, 8'h12, 0);
        rd_all("R2 after lat-lo write");

        // R4 latch-high write does not load
        cyc(1, 3'd3, 8'h00, 0);
        rd_all("R4 after lat-hi write");

        // R3 counter-high write loads, beats a tick
        cyc(1, 3'd1, 8'h00, 1);
        rd(3'd0, "R3 load beats tick lo");
        rd(3'd1, "R3 load beats tick hi");

        // R5 decrement
        repeat (5) cyc(0, 3'd0, 8'h00, 1);
        rd(3'd0, "R5 decrement lo");
        check("R5 model count", m_cnt, 16'h000D);

        // R6 / R7 first zero fires, later ones do not
        pulses = 0;
        for (int i = 0; i < 13; i++) begin cyc(0, 3'd0, 8'h00, 1); pulses += irq_set; end
        check("R6 one pulse at zero", 16'(pulses), 16'd1);
        pulses = 0;
        for (int i = 0; i < 65536; i++) begin cyc(0, 3'd0, 8'h00, 1); pulses += irq_set; end
        check("R7 no second one-shot pulse", 16'(pulses), 16'd0);
        rd_all("R7 after wrap");

        // R8 continuous period latch+2
        cyc(1, 3'd4, 8'h40, 0);
        cyc(1, 3'd2, 8'h03, 0);
        cyc(1, 3'd1, 8'h00, 0);
        t_last = -1; pulses = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(0, 3'd0, 8'h00, 1);
            if (irq_set) begin
                t_now = i;
                if (t_last >= 0) check("R8 period", 16'(t_now - t_last), 16'd5);
                t_last = t_now; pulses++;
            end
        end
        check("R8 pulse count", 16'(pulses), 16'd4);

        // R9 unmapped addresses ignored
        cyc(1, 3'd5, 8'hA5, 0);
        cyc(1, 3'd7, 8'h5A, 0);
        rd_all("R9 unmapped write ignored");

        // Random mix: small latch values so zeros occur often
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 16);
            logic [7:0] d = 8'($urandom % 8);
            if (r < 10)       cyc(0, 3'd0, 8'h00, 1);
            else if (r == 10) cyc(1, 3'd1, 8'h00, 1'($urandom));
            else if (r == 11) cyc(1, 3'd3, 8'h00, 1'($urandom));
            else if (r == 12) cyc(1, 3'($urandom % 3) == 3'd1 ? 3'd2 : 3'd0, d, 1'($urandom));
            else if (r == 13) cyc(1, 3'd4, ($urandom % 2) ? 8'h40 : 8'h00, 1'($urandom));
            else              rd(3'($urandom % 5), "R9 random readback");
        end
        rd_all("R5/R8 final readback");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule